// File: doc/BRIEF.md
# Parallel FIFO Adapter Host Register Bank

This block is the register file that a host bus sees in a 16-bit parallel FIFO adapter. A 4-bit register address selects a register, and reads and writes decode that address differently. A read at one address can return a sense byte, an identity word, a gathered status word, the data word from the receive path, or a 24-bit word counter. A write at the same address loads the outgoing data word, the control lines, the routing options, or the counter together with the mode bits.

The counter counts down once for each word that the handshake engine completes, stops at zero and flags zero in the status word. The block routes the direction and host-last-word signals onto the top two control lines, and the peripheral-last-word and attention signals onto the top status lines, whenever their routing options are set. It synchronizes the asynchronous attention input. It also keeps an interrupt-pending bit, which a rising attention edge sets while interrupts are enabled and which a read of the acknowledge address clears.

Top module: `fifo_adapter_regs`

## Requirements
- R1: Read data is combinational from `reg_addr`. Address 0x0 returns `rx_word`. Address 0x3 returns the revision in bits 10:8 and a 1 in bit 5 (0x0220 by default). Address 0x9 returns 0x0010. Every address not named in these requirements returns 0.
- R2: A write takes effect on the clock edge at which `wr_en` is sampled high. Address 0x0 loads `tx_word`, and address 0x1 loads the six user control bits from `wr_data[5:0]`.
- R3: Address 0xA reads and writes counter bits 15:0. Address 0xB bits 15:8 read and write counter bits 23:16, and a read of address 0xB returns 0 in bits 7:0.
- R4: A write to address 0xB decodes `wr_data` as follows. Bit 7 loads the interrupt enable. Bit 6 loads `out_enable`. Bits 2:0 load `hs_mode`. Bit 4 makes `last_clr` pulse high for one cycle. Bit 5 clears the whole counter, and the write then leaves bits 15:8 unused.
- R5: Each cycle with `word_done` high and no counter write lowers the counter by one. A counter at zero stays at zero, and status bit 11 is high exactly while the counter is zero.
- R6: Address 0x7 write bit 0 enables direction routing (set after reset). While it is set, `ctl_lines[5]` = `xfer_dir` and `ctl_lines[4]` = `host_last`. Otherwise those two lines carry the user bits. `ctl_lines[3:0]` always carry the user bits.
- R7: The status word at address 0x7 has these bits: 2:0 = `ext_status[2:0]`, 3 = `host_last`, 4 = `rx_ready`, 5 = `tx_ready`, 6 = `dev_flag`, 7 = `host_strobe`, 8 = `ext_status[3]`, 9 = status line 4, 10 = status line 5, 11 = counter zero, 12 = synchronized attention, 13 = `dev_last`, 14 = `fifo_edge`, 15 = `fifo_half`.
- R8: Address 0x7 write bit 1 enables last-word routing (clear after reset). While it is set, status line 4 shows `dev_last`, and otherwise it shows `ext_status[4]`. While interrupts are enabled, status line 5 shows the synchronized attention, and otherwise it shows `ext_status[5]`.
- R9: The sense byte at address 0x1 reads 0xC8, with bit 2 = interrupt enable and bit 0 = interrupt pending. Bits 15:8 read 0.
- R10: `irq` goes high on a rising edge of the synchronized `dev_attn` only while the interrupt enable is set. The edge reaches `irq` three clock edges after the input changes.
- R11: A cycle with `rd_en` high at address 0x9 clears `irq` at the next edge, unless a new attention edge arrives in that same cycle.
- R12: After reset the counter, user control bits, `tx_word`, `hs_mode`, `out_enable`, interrupt enable and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 4 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe (used for clear-on-read) |
| rd_data | output | 16 | Read data, combinational |
| rx_word | input | 16 | Word from the receive FIFO |
| tx_word | output | 16 | Outgoing data word |
| word_done | input | 1 | One word completed by the handshake engine |
| xfer_dir | input | 1 | Transfer direction from the handshake engine |
| host_last | input | 1 | Host last-word signal |
| dev_last | input | 1 | Peripheral last-word signal |
| dev_flag | input | 1 | Peripheral flag level |
| host_strobe | input | 1 | Host strobe level |
| dev_attn | input | 1 | Asynchronous attention from the peripheral |
| rx_ready | input | 1 | Receive path ready |
| tx_ready | input | 1 | Transmit path ready |
| fifo_edge | input | 1 | FIFO almost empty or full |
| fifo_half | input | 1 | FIFO half full |
| ext_status | input | 6 | External status lines |
| ctl_lines | output | 6 | Control lines to the peripheral |
| hs_mode | output | 3 | Handshake mode |
| out_enable | output | 1 | Output enable bit |
| last_clr | output | 1 | One-cycle clear pulse for the last-word latch |
| irq | output | 1 | Interrupt pending |

## Verification
Registered results become visible in the cycle after the write or count strobe. The bench drives each strobe on a falling edge and checks the outputs and read-backs on the next falling edge, which falls after the single rising edge that registers them. Read data has no register stage, so the bench checks it one time step after it sets the address. An attention edge needs two synchronizer stages plus the pending register, so the bench waits four falling edges after changing `dev_attn` before it looks at `irq` or at status bits 10 and 12.

// File: rtl/fifo_adapter_regs_pkg.sv
// Package: register addresses and fixed field values for the adapter register bank.
// Assumes a 4-bit register address and a 16-bit host data word.
package fifo_adapter_regs_pkg;
    localparam int WORD_W = 16;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_DATA   = 4'h0;
    localparam logic [ADDR_W-1:0] A_CTRL   = 4'h1;
    localparam logic [ADDR_W-1:0] A_IDENT  = 4'h3;
    localparam logic [ADDR_W-1:0] A_ADAPT  = 4'h7;
    localparam logic [ADDR_W-1:0] A_ACK    = 4'h9;
    localparam logic [ADDR_W-1:0] A_CNT_LO = 4'hA;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 4'hB;

    localparam logic [7:0]        SENSE_BASE = 8'hC8;
    localparam logic [WORD_W-1:0] ACK_WORD   = 16'h0010;

    // Fields decoded from a write to the high counter address.
    typedef struct packed {
        logic [7:0] cnt_hi;
        logic       irq_en;
        logic       out_en;
        logic       cnt_clr;
        logic       last_clr;
        logic       spare;
        logic [2:0] mode;
    } hi_write_t;
endpackage

// File: rtl/fifo_adapter_sync.sv
// Multi-stage synchronizer for one asynchronous level.
// Assumes that STAGES >= 2 and that the input is a slow level.
module fifo_adapter_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_async};
    end

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/fifo_adapter_counter.sv
// Word counter. It loads in a low part and a high part, counts down on word strobes and stops at zero.
// Assumes that CNT_W is between 17 and 24. Clear takes priority over loads, and loads take priority over counting.
module fifo_adapter_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_lo,
    input  logic             ld_hi,
    input  logic             clr,
    input  logic [15:0]      lo_val,
    input  logic [CNT_W-17:0] hi_val,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic             is_zero
);
    logic [CNT_W-1:0] cnt_q;

    // Update the count from clear, a load, or a completed word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (ld_lo || ld_hi) begin
            if (ld_lo) cnt_q[15:0]       <= lo_val;
            if (ld_hi) cnt_q[CNT_W-1:16] <= hi_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign cnt     = cnt_q;
    assign is_zero = (cnt_q == '0);
endmodule

// File: rtl/fifo_adapter_rdmux.sv
// Read-side address decoder. It selects one of the assembled register words combinationally.
// Assumes that the caller has already built the sense, identity and status words.
module fifo_adapter_rdmux #(
    parameter int CNT_W = 24
) (
    input  logic [3:0]       addr,
    input  logic [15:0]      rx_word,
    input  logic [7:0]       sense,
    input  logic [15:0]      ident,
    input  logic [15:0]      status,
    input  logic [CNT_W-1:0] cnt,
    output logic [15:0]      rd_data
);
    import fifo_adapter_regs_pkg::*;
    localparam int HI_W = CNT_W - 16;

    logic [7:0] cnt_hi_byte;

    // Zero-extend the counter high part into a byte.
    always_comb begin
        cnt_hi_byte = '0;
        cnt_hi_byte[HI_W-1:0] = cnt[CNT_W-1:16];
    end

    // Pick the read word by address. Unused addresses read as zero.
    always_comb begin
        unique case (addr)
            A_DATA:   rd_data = rx_word;
            A_CTRL:   rd_data = {8'h00, sense};
            A_IDENT:  rd_data = ident;
            A_ADAPT:  rd_data = status;
            A_ACK:    rd_data = ACK_WORD;
            A_CNT_LO: rd_data = cnt[15:0];
            A_CNT_HI: rd_data = {cnt_hi_byte, 8'h00};
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/fifo_adapter_regs.sv
// Host register bank of a 16-bit parallel FIFO adapter: write registers, line routing,
// status assembly, interrupt pending logic and the word counter.
// Assumes that all inputs except dev_attn are synchronous to clk. Reset is synchronous and active low.
module fifo_adapter_regs #(
    parameter int          CNT_W       = 24,
    parameter int          SYNC_STAGES = 2,
    parameter logic [2:0]  REVISION    = 3'd2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  reg_addr,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    input  logic        rd_en,
    output logic [15:0] rd_data,
    input  logic [15:0] rx_word,
    output logic [15:0] tx_word,
    input  logic        word_done,
    input  logic        xfer_dir,
    input  logic        host_last,
    input  logic        dev_last,
    input  logic        dev_flag,
    input  logic        host_strobe,
    input  logic        dev_attn,
    input  logic        rx_ready,
    input  logic        tx_ready,
    input  logic        fifo_edge,
    input  logic        fifo_half,
    input  logic [5:0]  ext_status,
    output logic [5:0]  ctl_lines,
    output logic [2:0]  hs_mode,
    output logic        out_enable,
    output logic        last_clr,
    output logic        irq
);
    import fifo_adapter_regs_pkg::*;
    localparam int HI_W = CNT_W - 16;

    hi_write_t        hi_fields;
    logic             wr_data_sel, wr_ctrl_sel, wr_adapt_sel, wr_lo_sel, wr_hi_sel, ack_rd;
    logic [15:0]      tx_q;
    logic [5:0]       ctl_user_q;
    logic             dir_route_q, last_route_q;
    logic [2:0]       mode_q;
    logic             out_en_q, irq_en_q, last_clr_q, irq_pend_q;
    logic             attn_s, attn_prev_q, attn_rise;
    logic [CNT_W-1:0] cnt_q;
    logic             cnt_zero;
    logic             line4, line5;
    logic [7:0]       sense_byte;
    logic [15:0]      ident_word, status_word;

    assign hi_fields    = hi_write_t'(wr_data);
    assign wr_data_sel  = wr_en && (reg_addr == A_DATA);
    assign wr_ctrl_sel  = wr_en && (reg_addr == A_CTRL);
    assign wr_adapt_sel = wr_en && (reg_addr == A_ADAPT);
    assign wr_lo_sel    = wr_en && (reg_addr == A_CNT_LO);
    assign wr_hi_sel    = wr_en && (reg_addr == A_CNT_HI);
    assign ack_rd       = rd_en && (reg_addr == A_ACK);

    // Load the data, control and routing registers from host writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q         <= '0;
            ctl_user_q   <= '0;
            dir_route_q  <= 1'b1;
            last_route_q <= 1'b0;
        end else begin
            if (wr_data_sel)  tx_q <= wr_data;
            if (wr_ctrl_sel)  ctl_user_q <= wr_data[5:0];
            if (wr_adapt_sel) begin
                dir_route_q  <= wr_data[0];
                last_route_q <= wr_data[1];
            end
        end
    end

    // Capture the mode fields carried by a high counter write. The last-word clear is a single-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q     <= '0;
            out_en_q   <= 1'b0;
            irq_en_q   <= 1'b0;
            last_clr_q <= 1'b0;
        end else begin
            last_clr_q <= wr_hi_sel && hi_fields.last_clr;
            if (wr_hi_sel) begin
                mode_q   <= hi_fields.mode;
                out_en_q <= hi_fields.out_en;
                irq_en_q <= hi_fields.irq_en;
            end
        end
    end

    fifo_adapter_sync #(.STAGES(SYNC_STAGES)) u_attn_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (dev_attn),
        .q_sync  (attn_s)
    );

    // Keep the previous synchronized attention level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) attn_prev_q <= 1'b0;
        else        attn_prev_q <= attn_s;
    end

    assign attn_rise = attn_s && !attn_prev_q;

    // Set the pending bit on an enabled attention edge, and clear it on an acknowledge read.
    always_ff @(posedge clk) begin
        if (!rst_n)                       irq_pend_q <= 1'b0;
        else if (attn_rise && irq_en_q)   irq_pend_q <= 1'b1;
        else if (ack_rd)                  irq_pend_q <= 1'b0;
    end

    fifo_adapter_counter #(.CNT_W(CNT_W)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_lo   (wr_lo_sel),
        .ld_hi   (wr_hi_sel && !hi_fields.cnt_clr),
        .clr     (wr_hi_sel && hi_fields.cnt_clr),
        .lo_val  (wr_data),
        .hi_val  (hi_fields.cnt_hi[HI_W-1:0]),
        .dec     (word_done),
        .cnt     (cnt_q),
        .is_zero (cnt_zero)
    );

    // Route the optional signals onto the top control and status lines.
    always_comb begin
        ctl_lines = ctl_user_q;
        if (dir_route_q) ctl_lines[5:4] = {xfer_dir, host_last};
        line4 = last_route_q ? dev_last : ext_status[4];
        line5 = irq_en_q     ? attn_s   : ext_status[5];
    end

    // Assemble the sense, identity and status words.
    always_comb begin
        sense_byte  = SENSE_BASE | {5'b0, irq_en_q, 1'b0, irq_pend_q};
        ident_word  = {5'b0, REVISION, 2'b0, 1'b1, 5'b0};
        status_word = {fifo_half, fifo_edge, dev_last, attn_s, cnt_zero,
                       line5, line4, ext_status[3],
                       host_strobe, dev_flag, tx_ready, rx_ready,
                       host_last, ext_status[2:0]};
    end

    fifo_adapter_rdmux #(.CNT_W(CNT_W)) u_rdmux (
        .addr    (reg_addr),
        .rx_word (rx_word),
        .sense   (sense_byte),
        .ident   (ident_word),
        .status  (status_word),
        .cnt     (cnt_q),
        .rd_data (rd_data)
    );

    assign tx_word    = tx_q;
    assign hs_mode    = mode_q;
    assign out_enable = out_en_q;
    assign last_clr   = last_clr_q;
    assign irq        = irq_pend_q;
endmodule

// File: rtl/fifo_adapter_regs_chk.sv
// Checker for the adapter register bank. It holds temporal properties on ports and internal state.
// Assumes that it is attached by the bind statement at the end of this file.
module fifo_adapter_regs_chk #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       reg_addr,
    input  logic             wr_en,
    input  logic [15:0]      wr_data,
    input  logic             rd_en,
    input  logic             word_done,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic             irq_en_q,
    input  logic             attn_rise,
    input  logic             irq,
    input  logic [5:0]       ctl_lines,
    input  logic [15:0]      tx_word,
    input  logic             out_enable,
    input  logic             last_clr
);
    logic cnt_wr;
    assign cnt_wr = wr_en && (reg_addr == 4'hA || reg_addr == 4'hB);

    assert_cnt_dec_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && !cnt_wr && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    assert_cnt_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && !cnt_wr && cnt_q == '0) |=> (cnt_q == '0));

    assert_irq_needs_en_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !irq_en_q) |=> !irq);

    assert_irq_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && reg_addr == 4'h9 && !attn_rise) |=> !irq);

    assert_ctl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_addr == 4'h1) |=> (ctl_lines[3:0] == $past(wr_data[3:0])));

    assert_tx_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_addr == 4'h0) |=> (tx_word == $past(wr_data)));

    assert_out_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_addr == 4'hB) |=> (out_enable == $past(wr_data[6])));

    assert_last_clr_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && reg_addr == 4'hB && wr_data[4])) |=> !last_clr);
endmodule

bind fifo_adapter_regs fifo_adapter_regs_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr   (reg_addr),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_en      (rd_en),
    .word_done  (word_done),
    .cnt_q      (cnt_q),
    .irq_en_q   (irq_en_q),
    .attn_rise  (attn_rise),
    .irq        (irq),
    .ctl_lines  (ctl_lines),
    .tx_word    (tx_word),
    .out_enable (out_enable),
    .last_clr   (last_clr)
);

// File: tb/fifo_adapter_regs_tb.sv
// Self-checking bench: directed corner cases plus seeded random register traffic against a bench model.
module fifo_adapter_regs_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;
    logic [15:0] rx_word = '0;
    logic [15:0] tx_word;
    logic        word_done = 1'b0;
    logic        xfer_dir = 1'b0, host_last = 1'b0, dev_last = 1'b0, dev_flag = 1'b0;
    logic        host_strobe = 1'b0, dev_attn = 1'b0, rx_ready = 1'b0, tx_ready = 1'b0;
    logic        fifo_edge = 1'b0, fifo_half = 1'b0;
    logic [5:0]  ext_status = '0;
    logic [5:0]  ctl_lines;
    logic [2:0]  hs_mode;
    logic        out_enable, last_clr, irq;

    fifo_adapter_regs u_dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;

    // Bench model of the state that the requirements define.
    logic [23:0] m_cnt = '0;
    logic [15:0] m_tx = '0;
    logic [5:0]  m_ctl = '0;
    logic        m_dir_rt = 1'b1, m_last_rt = 1'b0;
    logic [2:0]  m_mode = '0;
    logic        m_oen = 1'b0, m_irq_en = 1'b0, m_irq = 1'b0, m_attn = 1'b0;
    logic        seen_clr;

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_status();
        logic l4, l5;
        l4 = m_last_rt ? dev_last : ext_status[4];
        l5 = m_irq_en ? m_attn : ext_status[5];
        return {fifo_half, fifo_edge, dev_last, m_attn, (m_cnt == 0), l5, l4, ext_status[3],
                host_strobe, dev_flag, tx_ready, rx_ready, host_last, ext_status[2:0]};
    endfunction

    function automatic logic [15:0] exp_read(input logic [3:0] a);
        case (a)
            4'h0: return rx_word;
            4'h1: return {8'h00, 8'hC8 | {5'b0, m_irq_en, 1'b0, m_irq}};
            4'h3: return 16'h0220;
            4'h7: return exp_status();
            4'h9: return 16'h0010;
            4'hA: return m_cnt[15:0];
            4'hB: return {m_cnt[23:16], 8'h00};
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic [5:0] exp_ctl();
        return m_dir_rt ? {xfer_dir, host_last, m_ctl[3:0]} : m_ctl;
    endfunction

    // Write one register. The result is visible at the falling edge after the registering edge.
    task automatic do_write(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        seen_clr = last_clr;
        case (a)
            4'h0: m_tx = d;
            4'h1: m_ctl = d[5:0];
            4'h7: begin m_dir_rt = d[0]; m_last_rt = d[1]; end
            4'hA: m_cnt[15:0] = d;
            4'hB: begin
                if (d[5]) m_cnt = '0; else m_cnt[23:16] = d[15:8];
                m_irq_en = d[7]; m_oen = d[6]; m_mode = d[2:0];
            end
            default: ;
        endcase
    endtask

    task automatic pulse_word();
        @(negedge clk);
        word_done = 1'b1;
        @(negedge clk);
        word_done = 1'b0;
        if (m_cnt != 0) m_cnt = m_cnt - 1;
    endtask

    task automatic check_read(input logic [3:0] a, input string req);
        reg_addr = a;
        #1;
        check(rd_data, exp_read(a), req);
    endtask

    task automatic rand_inputs();
        {xfer_dir, host_last, dev_last, dev_flag, host_strobe, rx_ready, tx_ready, fifo_edge, fifo_half} = 9'($urandom);
        ext_status = 6'($urandom);
        rx_word = 16'($urandom);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd7));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        host_last = 1'b1; xfer_dir = 1'b1; #1;
        check(ctl_lines, 6'b110000, "R12 ctl after reset");
        check({hs_mode, out_enable, irq, tx_word}, 21'h0, "R12 outputs after reset");
        check_read(4'hA, "R12 counter low zero");
        check_read(4'h1, "R9 sense after reset");

        // R1 fixed reads
        rx_word = 16'hBEEF;
        check_read(4'h0, "R1 rx word");
        check_read(4'h3, "R1 ident");
        check_read(4'h9, "R1 ack word");
        check_read(4'h5, "R1 unused address");
        check_read(4'hF, "R1 unused address F");

        // R2 tx and ctl writes
        do_write(4'h0, 16'h1234);
        check(tx_word, 16'h1234, "R2 tx word");
        do_write(4'h1, 16'h003F);
        #1 check(ctl_lines, exp_ctl(), "R6 routed ctl");
        do_write(4'h7, 16'h0000);
        #1 check(ctl_lines, 6'h3F, "R6 user ctl when routing off");

        // R3/R4 counter split and mode fields
        do_write(4'hA, 16'h0002);
        do_write(4'hB, 16'hA5D3);
        check_read(4'hB, "R3 high byte, low byte zero");
        check({hs_mode, out_enable}, {3'd3, 1'b1}, "R4 mode and out enable");
        check(seen_clr, 1'b1, "R4 last clear pulse");
        @(negedge clk);
        check(last_clr, 1'b0, "R4 last clear single cycle");
        check_read(4'h1, "R9 sense with enable");
        do_write(4'hB, 16'h7720);
        check_read(4'hB, "R4 counter clear ignores high byte");
        check_read(4'hA, "R4 counter clear low");

        // R5 counting down through zero
        do_write(4'hA, 16'h0002);
        pulse_word();
        check_read(4'hA, "R5 decrement");
        pulse_word();
        check_read(4'h7, "R5 zero flag status");
        pulse_word();
        check_read(4'hA, "R5 hold at zero");

        // R8 last-word routing on status line 4
        do_write(4'h7, 16'h0002);
        dev_last = 1'b1; ext_status = 6'h00;
        check_read(4'h7, "R8 line4 shows dev_last");

        // R10 edge while disabled does nothing
        do_write(4'hB, 16'h0000);
        @(negedge clk); dev_attn = 1'b1; m_attn = 1'b0;
        repeat (4) @(negedge clk);
        m_attn = 1'b1;
        check(irq, 1'b0, "R10 no irq while disabled");
        check_read(4'h7, "R7 attention bit with ext line5");
        dev_attn = 1'b0;
        repeat (4) @(negedge clk);
        m_attn = 1'b0;
        do_write(4'hB, 16'h0080);
        @(negedge clk); dev_attn = 1'b1;
        @(negedge clk); @(negedge clk);
        check(irq, 1'b0, "R10 not yet after two edges");
        @(negedge clk);
        check(irq, 1'b1, "R10 irq on third edge");
        m_attn = 1'b1; m_irq = 1'b1;
        check_read(4'h7, "R8 line5 shows attention");
        check_read(4'h1, "R9 pending in sense");

        // R11 acknowledge read clears pending
        reg_addr = 4'h9; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0; m_irq = 1'b0;
        check(irq, 1'b0, "R11 ack clears irq");
        dev_attn = 1'b0;
        repeat (4) @(negedge clk);
        m_attn = 1'b0;

        // Random register traffic against the model
        for (int i = 0; i < 600; i++) begin
            int op;
            logic [3:0] a;
            op = int'($urandom_range(0, 5));
            rand_inputs();
            case (op)
                0: do_write(4'h1, 16'($urandom));
                1: do_write(4'h7, 16'($urandom));
                2: do_write(4'hA, 16'($urandom_range(0, 6)));
                3: do_write(4'hB, 16'($urandom) & 16'hFFEF);
                4: pulse_word();
                default: do_write(4'h0, 16'($urandom));
            endcase
            a = 4'($urandom);
            check_read(a, "R7 random read");
            check(ctl_lines, exp_ctl(), "R6 random ctl");
            check({tx_word, hs_mode, out_enable}, {m_tx, m_mode, m_oen}, "R2 random regs");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule